// File: doc/BRIEF.md
# Single-Cycle Word-Datapath Processor Core

This block is a compact 32-bit processor that retires one instruction per clock edge. It supports six operations: register add and subtract, OR with an unsigned immediate, word load, word store, and branch-if-equal. The program counter, the register file and the data memory all change state on the same rising edge. The instruction memory and the data memory are arrays held inside the block. They are filled from outside the block before the program runs.

Register operands are read combinationally from a 32-entry, 32-bit register file with two read ports and one write port. An immediate extender feeds the ALU. It zero-extends the immediate for logical operations and sign-extends it for address arithmetic and branch offsets. Each instruction class selects three things: the write-back target (the rd or rt field), the second ALU operand (register or immediate), and the write-back source (ALU result or loaded word).

A set of trace outputs shows the register write and the memory write that will be committed at the next edge, together with the current program counter. Software-free checking can be built on these outputs.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and no register or memory write takes place. The contents of the register file and of both memories are kept across reset.
- R2: The instruction is the instruction-memory word indexed by PC bits [7:2] (64 words). Instruction bit fields are: op [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], imm [15:0]. Except for a taken branch, the PC advances by 4 each cycle.
- R3: op 0x00 with funct 0x21 writes rd with rs+rt. op 0x00 with funct 0x23 writes rd with rs-rt. Both results wrap modulo 2^32.
- R4: op 0x0D writes rt with rs OR the zero-extended imm.
- R5: op 0x23 writes rt with the data-memory word at index bits [9:2] of the byte address rs + sign-extended imm. Address bits above 9 and bits [1:0] are ignored.
- R6: op 0x2B writes the value of rt into the data-memory word at the same index as in R5, with no register write. A load in the following cycle returns the stored word.
- R7: op 0x04 compares rs and rt. If they are equal, the next PC is PC+4+(sign-extended imm × 4); otherwise it is PC+4. No register or memory write takes place.
- R8: A write that targets register 0 is dropped, and register 0 always reads as zero.
- R9: Any other op value, and any other funct value with op 0x00, makes no register or memory write and advances the PC by 4.
- R10: `rf_we_o` is high exactly when a register with a nonzero index will be written at the next edge, with `rf_wa_o`/`rf_wd_o` giving its index and value. `dm_we_o` is high exactly when a store will commit, with `dm_addr_o` giving the full byte address and `dm_wd_o` the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write committing at the next edge |
| rf_wa_o | output | 5 | Register index being written |
| rf_wd_o | output | 32 | Value being written to the register |
| dm_we_o | output | 1 | Store committing at the next edge |
| dm_addr_o | output | 32 | Byte address of the data access |
| dm_wd_o | output | 32 | Store data |

## Verification
The hardest case to reach from the ports is a load in the cycle right after a store to the same word, combined with address aliasing. In that case a differently formed byte address (negative offset from register 0, or bits above 9 set) must land on the same memory word. A directed prologue builds exactly these cases and chains a taken branch off the loaded value, so a lost same-edge update would show up in both the data and the PC. Seeded random programs then mix all six classes with illegal encodings and short forward and backward branches over a small set of registers that includes register 0. A reference model in the bench tracks every write. Resets are placed mid-program, and later loads show that memory contents survived them.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_LOADW = 6'h23;
   localparam logic [5:0] OP_STORW = 6'h2B;
   localparam logic [5:0] OP_BREQ  = 6'h04;

   localparam logic [5:0] FN_ADDU  = 6'h21;
   localparam logic [5:0] FN_SUBU  = 6'h23;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    reg_wr;    // instruction writes a register
      logic    dst_rd;    // 1: target is rd field, 0: rt field
      logic    imm_src;   // 1: second ALU operand is the immediate
      logic    ext_sign;  // 1: sign-extend imm, 0: zero-extend
      logic    load;      // write-back value comes from data memory
      logic    store;     // data memory write
      logic    branch;    // conditional PC redirect on equality
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic [5:0]  op,
   input  logic [5:0]  funct,
   output ctrl_t       ctrl
);

   always_comb begin
      ctrl = '0;
      ctrl.alu_op = ALU_ADD;
      unique case (op)
         OP_RTYPE: begin
            if (funct == FN_ADDU) begin
               ctrl.reg_wr = 1'b1;
               ctrl.dst_rd = 1'b1;
            end else if (funct == FN_SUBU) begin
               ctrl.reg_wr = 1'b1;
               ctrl.dst_rd = 1'b1;
               ctrl.alu_op = ALU_SUB;
            end
         end
         OP_ORI: begin
            ctrl.reg_wr  = 1'b1;
            ctrl.imm_src = 1'b1;
            ctrl.alu_op  = ALU_OR;
         end
         OP_LOADW: begin
            ctrl.reg_wr   = 1'b1;
            ctrl.imm_src  = 1'b1;
            ctrl.ext_sign = 1'b1;
            ctrl.load     = 1'b1;
         end
         OP_STORW: begin
            ctrl.imm_src  = 1'b1;
            ctrl.ext_sign = 1'b1;
            ctrl.store    = 1'b1;
         end
         OP_BREQ: begin
            ctrl.ext_sign = 1'b1;
            ctrl.branch   = 1'b1;
            ctrl.alu_op   = ALU_SUB;
         end
         default: ;
      endcase
   end

   // R6 R7 R9: an instruction has at most one kind of side effect
   one_effect_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctrl.reg_wr, ctrl.store, ctrl.branch}));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter bit SHARED_ADDR = 1'b1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y,
   output logic            eq
);

   logic [XLEN-1:0] arith;

   generate
      if (SHARED_ADDR) begin : g_shared
         logic            inv;
         logic [XLEN-1:0] b_eff;
         assign inv   = (op == ALU_SUB);
         assign b_eff = b ^ {XLEN{inv}};
         assign arith = a + b_eff + {{(XLEN-1){1'b0}}, inv};
      end else begin : g_split
         assign arith = (op == ALU_SUB) ? (a - b) : (a + b);
      end
   endgenerate

   assign y  = (op == ALU_OR) ? (a | b) : arith;
   assign eq = ~|(a ^ b);

   // R3: a difference added back to the subtrahend restores the minuend
   always_comb begin
      if (op == ALU_SUB && !$isunknown({a, b})) begin
         sub_inverse_chk: assert (y + b == a);
      end
   end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int XLEN  = 32,
   parameter int NREGS = 32,
   parameter int NRD   = 2,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [AW-1:0]             wa,
   input  logic [XLEN-1:0]           wd,
   input  logic [NRD-1:0][AW-1:0]    ra,
   output logic [NRD-1:0][XLEN-1:0]  rdata
);

   generate
      if (NREGS < 2 || (1 << AW) != NREGS) begin : g_bad_depth
         $error("sc_regfile: NREGS must be a power of two >= 2");
      end
      if (NRD < 1) begin : g_bad_ports
         $error("sc_regfile: at least one read port required");
      end
   endgenerate

   logic [XLEN-1:0] regs_q [NREGS];

   always_ff @(posedge clk) begin
      if (we) regs_q[wa] <= wd;
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g] = (ra[g] == '0) ? '0 : regs_q[ra[g]];
   end

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int  XLEN       = 32,
   parameter int  IMEM_WORDS = 64,
   parameter int  DMEM_WORDS = 256,
   parameter int  NREGS      = 32,
   parameter bit  SHARED_ADD = 1'b1,
   localparam int IA         = $clog2(IMEM_WORDS),
   localparam int DA         = $clog2(DMEM_WORDS),
   localparam int RA         = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst,
   output logic [31:0]     pc_o,
   output logic            rf_we_o,
   output logic [4:0]      rf_wa_o,
   output logic [31:0]     rf_wd_o,
   output logic            dm_we_o,
   output logic [31:0]     dm_addr_o,
   output logic [31:0]     dm_wd_o
);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("sc_core: instruction layout fixes XLEN at 32");
      end
      if (NREGS != 32) begin : g_bad_regs
         $error("sc_core: 5-bit register fields need 32 registers");
      end
      if (IMEM_WORDS < 2 || (1 << IA) != IMEM_WORDS) begin : g_bad_imem
         $error("sc_core: IMEM_WORDS must be a power of two");
      end
      if (DMEM_WORDS < 2 || (1 << DA) != DMEM_WORDS) begin : g_bad_dmem
         $error("sc_core: DMEM_WORDS must be a power of two");
      end
   endgenerate

   // storage, preloaded from outside before a program runs
   logic [XLEN-1:0] imem_q [IMEM_WORDS];
   logic [XLEN-1:0] dmem_q [DMEM_WORDS];
   logic [XLEN-1:0] pc_q;

   // fetch and field split
   logic [XLEN-1:0] instr;
   logic [5:0]      f_op, f_fn;
   logic [RA-1:0]   f_rs, f_rt, f_rd;
   logic [15:0]     f_imm;

   assign instr = imem_q[pc_q[IA+1:2]];
   assign f_op  = instr[31:26];
   assign f_rs  = instr[25:21];
   assign f_rt  = instr[20:16];
   assign f_rd  = instr[15:11];
   assign f_fn  = instr[5:0];
   assign f_imm = instr[15:0];

   ctrl_t ctrl;

   sc_decode u_dec (
      .clk   (clk),
      .rst   (rst),
      .op    (f_op),
      .funct (f_fn),
      .ctrl  (ctrl)
   );

   // operand read
   logic [1:0][RA-1:0]   rd_sel;
   logic [1:0][XLEN-1:0] rd_val;
   logic                 rf_we;
   logic [RA-1:0]        rf_wa;
   logic [XLEN-1:0]      rf_wd;

   assign rd_sel[0] = f_rs;
   assign rd_sel[1] = f_rt;

   sc_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(2)) u_rf (
      .clk   (clk),
      .we    (rf_we),
      .wa    (rf_wa),
      .wd    (rf_wd),
      .ra    (rd_sel),
      .rdata (rd_val)
   );

   // immediate extension and execute
   logic [XLEN-1:0] imm_x, alu_b, alu_y;
   logic            alu_eq;

   assign imm_x = ctrl.ext_sign ? {{(XLEN-16){f_imm[15]}}, f_imm}
                                : {{(XLEN-16){1'b0}}, f_imm};
   assign alu_b = ctrl.imm_src ? imm_x : rd_val[1];

   sc_alu #(.XLEN(XLEN), .SHARED_ADDR(SHARED_ADD)) u_alu (
      .a  (rd_val[0]),
      .b  (alu_b),
      .op (ctrl.alu_op),
      .y  (alu_y),
      .eq (alu_eq)
   );

   // data memory access
   logic [DA-1:0]   dm_idx;
   logic [XLEN-1:0] dm_rdata;
   logic            dm_we;

   assign dm_idx   = alu_y[DA+1:2];
   assign dm_rdata = dmem_q[dm_idx];
   assign dm_we    = !rst && ctrl.store;

   always_ff @(posedge clk) begin
      if (dm_we) dmem_q[dm_idx] <= rd_val[1];
   end

   // write-back
   assign rf_wa = ctrl.dst_rd ? f_rd : f_rt;
   assign rf_wd = ctrl.load ? dm_rdata : alu_y;
   assign rf_we = !rst && ctrl.reg_wr && (rf_wa != '0);

   // next PC
   logic            br_taken;
   logic [XLEN-1:0] pc_seq, pc_next;

   assign br_taken = ctrl.branch && alu_eq;
   assign pc_seq   = pc_q + XLEN'(4);
   assign pc_next  = br_taken ? (pc_seq + {imm_x[XLEN-3:0], 2'b00}) : pc_seq;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   // trace outputs
   assign pc_o      = pc_q;
   assign rf_we_o   = rf_we;
   assign rf_wa_o   = rf_wa;
   assign rf_wd_o   = rf_wd;
   assign dm_we_o   = dm_we;
   assign dm_addr_o = alu_y;
   assign dm_wd_o   = rd_val[1];

   // R1
   pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> pc_q == '0);

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(br_taken)) |-> pc_q == $past(pc_q) + XLEN'(4));

   // R6
   store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
      dm_we_o |-> !rf_we_o);

endmodule

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;

   localparam int IW = 64;
   localparam int DW = 256;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [31:0] pc_o, rf_wd_o, dm_addr_o, dm_wd_o;
   logic [4:0]  rf_wa_o;
   logic        rf_we_o, dm_we_o;

   sc_core u0 (
      .clk(clk), .rst(rst), .pc_o(pc_o),
      .rf_we_o(rf_we_o), .rf_wa_o(rf_wa_o), .rf_wd_o(rf_wd_o),
      .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wd_o(dm_wd_o)
   );

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] m_imem [IW];
   logic [31:0] m_dmem [DW];
   logic [31:0] m_regs [32];
   logic [31:0] m_pc;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h pc=%h", tag, what, act, exp, m_pc);
      end
   endtask

   function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
      return {6'h00, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] sx(logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   task automatic put_imem(int i, logic [31:0] v);
      m_imem[i] = v;
      u0.imem_q[i] = v;
   endtask

   // one instruction: compare trace against the model, then commit the model
   task automatic step_check();
      logic [31:0] ins, a, b, ew_d, ed_a, npc;
      logic [5:0]  op, fn;
      logic [4:0]  rs, rt, rd, ew_a;
      logic        ew, ed;
      string       tag;
      ins = m_imem[m_pc[7:2]];
      op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
      a = m_regs[rs]; b = m_regs[rt];
      ew = 1'b0; ew_a = 5'd0; ew_d = '0; ed = 1'b0; ed_a = '0;
      npc = m_pc + 32'd4;
      tag = "R9";
      if (op == 6'h00 && fn == 6'h21) begin
         ew_a = rd; ew_d = a + b; tag = "R3";
      end else if (op == 6'h00 && fn == 6'h23) begin
         ew_a = rd; ew_d = a - b; tag = "R3";
      end else if (op == 6'h0D) begin
         ew_a = rt; ew_d = a | {16'h0, ins[15:0]}; tag = "R4";
      end else if (op == 6'h23) begin
         ed_a = a + sx(ins[15:0]);
         ew_a = rt; ew_d = m_dmem[ed_a[9:2]]; tag = "R5";
      end else if (op == 6'h2B) begin
         ed = 1'b1; ed_a = a + sx(ins[15:0]); tag = "R6";
      end else if (op == 6'h04) begin
         tag = "R7";
         if (a == b) npc = m_pc + 32'd4 + {sx(ins[15:0])[29:0], 2'b00};
      end
      if (tag == "R3" || tag == "R4" || tag == "R5") begin
         ew = (ew_a != 5'd0);
         if (!ew) tag = "R8";
      end
      chk((tag == "R7") ? "R7" : "R2", "pc", pc_o, m_pc);
      chk(tag, "rf_we (R10)", {31'd0, rf_we_o}, {31'd0, ew});
      if (ew) begin
         chk(tag, "rf_wa", {27'd0, rf_wa_o}, {27'd0, ew_a});
         chk(tag, "rf_wd", rf_wd_o, ew_d);
      end
      chk(tag, "dm_we (R10)", {31'd0, dm_we_o}, {31'd0, ed});
      if (ed) begin
         chk(tag, "dm_addr", dm_addr_o, ed_a);
         chk(tag, "dm_wd", dm_wd_o, b);
      end
      if (ew) m_regs[ew_a] = ew_d;
      if (ed) m_dmem[ed_a[9:2]] = b;
      m_pc = npc;
   endtask

   task automatic run(int n);
      repeat (n) begin
         step_check();
         @(negedge clk); #0.5;
      end
   endtask

   // R1: two reset cycles, PC zero and no writes; leaves rst low at mid-cycle
   task automatic do_reset(bit random_load);
      rst = 1'b1;
      if (random_load) load_random();
      repeat (2) begin
         @(negedge clk); #0.5;
         chk("R1", "pc in reset", pc_o, 32'd0);
         chk("R1", "rf_we in reset", {31'd0, rf_we_o}, 32'd0);
         chk("R1", "dm_we in reset", {31'd0, dm_we_o}, 32'd0);
      end
      m_pc = 32'd0;
      rst = 1'b0;
      #0.5;
   endtask

   task automatic load_random();
      for (int i = 0; i < IW; i++) begin
         logic [4:0]  ra, rb, rc;
         logic [15:0] imm;
         int          k;
         ra = 5'($urandom % 8); rb = 5'($urandom % 8); rc = 5'($urandom % 8);
         imm = 16'($urandom);
         k = $urandom % 9;
         case (k)
            0: put_imem(i, enc_r(6'h21, rc, ra, rb));
            1: put_imem(i, enc_r(6'h23, rc, ra, rb));
            2, 3: put_imem(i, enc_i(6'h0D, rc, ra, imm));
            4: put_imem(i, enc_i(6'h23, rc, ra, imm));
            5: put_imem(i, enc_i(6'h2B, rb, ra, imm));
            6: put_imem(i, enc_i(6'h04, rb, ra, 16'(int'($urandom % 9) - 4)));
            7: put_imem(i, enc_i(6'h3E, rc, ra, imm));
            default: put_imem(i, enc_r(6'h22, rc, ra, rb));
         endcase
      end
   endtask

   initial begin
      void'($urandom(32'd20240717));
      for (int i = 0; i < DW; i++) begin
         m_dmem[i] = $urandom;
         u0.dmem_q[i] = m_dmem[i];
      end
      for (int i = 0; i < 32; i++) m_regs[i] = '0;
      // directed prologue
      put_imem(0,  enc_i(6'h0D, 5'd1, 5'd0, 16'hFFFF));   // R4 r1 = 0xFFFF
      put_imem(1,  enc_i(6'h0D, 5'd2, 5'd0, 16'h0010));   // R4 r2 = 0x10
      put_imem(2,  enc_i(6'h0D, 5'd0, 5'd0, 16'h1234));   // R8 write to r0 dropped
      put_imem(3,  enc_r(6'h21, 5'd3, 5'd0, 5'd0));       // R8 r3 = r0 + r0 = 0
      put_imem(4,  enc_r(6'h21, 5'd4, 5'd1, 5'd2));       // R3 0x1000F
      put_imem(5,  enc_r(6'h23, 5'd5, 5'd2, 5'd1));       // R3 wraps 0xFFFF0011
      put_imem(6,  enc_i(6'h2B, 5'd5, 5'd2, 16'hFFFC));   // R6 store to byte 0xC
      put_imem(7,  enc_i(6'h23, 5'd6, 5'd2, 16'hFFFC));   // R6 load next cycle
      put_imem(8,  enc_i(6'h23, 5'd7, 5'd0, 16'h03FC));   // R5 top word
      put_imem(9,  enc_i(6'h04, 5'd5, 5'd6, 16'h0002));   // R7 taken forward
      put_imem(10, enc_i(6'h0D, 5'd3, 5'd0, 16'h0001));   // skipped
      put_imem(11, enc_i(6'h0D, 5'd3, 5'd0, 16'h0002));   // skipped
      put_imem(12, enc_i(6'h04, 5'd2, 5'd1, 16'h0005));   // R7 not taken
      put_imem(13, enc_i(6'h3F, 5'd3, 5'd1, 16'h7777));   // R9 bad op
      put_imem(14, enc_r(6'h20, 5'd3, 5'd1, 5'd2));       // R9 bad funct
      put_imem(15, enc_i(6'h2B, 5'd1, 5'd0, 16'hFFFC));   // R5 alias word 255
      put_imem(16, enc_i(6'h23, 5'd3, 5'd0, 16'h03FC));   // R5 reads 0xFFFF
      put_imem(17, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));   // R7 backward, self loop
      for (int i = 18; i < IW; i++) put_imem(i, 32'h0000_0000); // R9 filler
      do_reset(1'b0);
      run(24);
      // R1: reset mid-run with a new program; memory and registers persist
      do_reset(1'b1);
      run(500);
      do_reset(1'b1);
      run(500);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule